// File: doc/BRIEF.md
# Bufferless Deflection Router for a 3D Mesh

This block is one node of a three-dimensional mesh network-on-chip. It has six neighbour links (plus and minus along X, Y and Z) and one local link to a processing element. Each link is a pair of one-way 16-bit flit channels, one in and one out. The router stores no flits. In every cycle it takes all arriving flits, picks an output for each one, and registers the result on the outputs. Each flit therefore crosses the node in exactly one clock cycle.

Each flit has a preferred direction. The router corrects the X offset first, then Y, then Z, and a flit with no offset left goes to the local port. When two flits want the same output, a fixed priority settles it. The flit that loses is deflected to any other free neighbour output, so no transit flit is ever held back. Outputs that would leave the mesh are never used. A flit from the local element enters only when an output is left for it. Otherwise the router raises a stall back to that element, and the element must hold its flit.

The node's mesh position and the mesh size are parameters. The default is the centre node of a 3 x 3 x 3 mesh.

Top module: `mesh3d_defl_router`

## Requirements
- R1: While reset is active and on the first cycle after it, every output flit has its valid bit (bit 15) at 0, and `loc_stall` is 0.
- R2: Flit format: bit 15 is valid, bits 14:13 are destination X, bits 12:11 are destination Y, bits 10:9 are destination Z, and bits 8:0 are payload. An uncontended flit leaves, unchanged, on the port that fixes its first nonzero offset, checked in the order X, Y, Z. The ports are index 0 +X, 1 -X, 2 +Y, 3 -Y, 4 +Z, 5 -Z.
- R3: A flit whose destination equals the node's coordinates leaves on `loc_out`, provided no other flit has already taken that output.
- R4: A flit that arrives in cycle t is on its output after the next rising edge. It is gone one cycle later unless a new flit replaces it.
- R5: Requests are served in the order network input 0 to 5, then the local input. A flit whose preferred output is taken goes to the lowest-numbered free output that exists.
- R6: At most one flit is ejected per cycle. Other flits addressed to this node are deflected under the rule in R5.
- R7: A valid local flit is accepted only if an output is still free after all transit flits are assigned. `loc_stall` is combinational: it is 1 exactly when a valid local flit cannot be accepted, and a stalled flit appears on no output.
- R8: An output that would leave the mesh never carries a valid flit. A flit driven on an input from outside the mesh is ignored.
- R9: The number of valid output flits after an edge equals the number of valid network inputs plus the accepted local flit before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| net_in | input | 6x16 | Incoming flits from neighbours, index 0 +X, 1 -X, 2 +Y, 3 -Y, 4 +Z, 5 -Z |
| net_out | output | 6x16 | Registered outgoing flits to neighbours, same indexing |
| loc_in | input | 16 | Flit offered by the local element |
| loc_stall | output | 1 | Local flit not accepted this cycle |
| loc_out | output | 16 | Registered flit ejected to the local element |

## Verification
Single flits injected toward each of the six directions test whether X is corrected before Y and Y before Z. A flit sent into the node on one side and out the other separates transit traffic from injection. Pairs of flits that want the same output, or that are both addressed to this node, show both the priority order and where the losing flit is deflected. Fully loaded cycles with and without a local flit test the stall decision and that flits are conserved. A corner node driven with traffic on a missing link checks that edge outputs are masked and edge inputs are ignored.

// File: rtl/router3d_pkg.sv
package router3d_pkg;
    localparam int NNET   = 6;
    localparam int NREQ   = NNET + 1;
    localparam int LOCIDX = NNET;
    localparam int PW     = 3;

    typedef enum logic [PW-1:0] {
        DIR_XP  = 3'd0,
        DIR_XM  = 3'd1,
        DIR_YP  = 3'd2,
        DIR_YM  = 3'd3,
        DIR_ZP  = 3'd4,
        DIR_ZM  = 3'd5,
        DIR_LOC = 3'd6
    } dir_e;
endpackage

// File: rtl/xyz_route_unit.sv
module xyz_route_unit
    import router3d_pkg::*;
#(
    parameter int FLIT_W  = 16,
    parameter int COORD_W = 2,
    parameter int MY_X    = 1,
    parameter int MY_Y    = 1,
    parameter int MY_Z    = 1
) (
    input  logic [FLIT_W-1:0] flit,
    output dir_e              pref,
    output logic              to_self
);
    localparam int XHI = FLIT_W - 2;
    localparam int YHI = XHI - COORD_W;
    localparam int ZHI = YHI - COORD_W;
    localparam logic [COORD_W-1:0] HX = COORD_W'(MY_X);
    localparam logic [COORD_W-1:0] HY = COORD_W'(MY_Y);
    localparam logic [COORD_W-1:0] HZ = COORD_W'(MY_Z);

    logic [COORD_W-1:0] dx, dy, dz;

    assign dx = flit[XHI -: COORD_W];
    assign dy = flit[YHI -: COORD_W];
    assign dz = flit[ZHI -: COORD_W];

    always_comb begin
        if      (dx > HX) pref = DIR_XP;
        else if (dx < HX) pref = DIR_XM;
        else if (dy > HY) pref = DIR_YP;
        else if (dy < HY) pref = DIR_YM;
        else if (dz > HZ) pref = DIR_ZP;
        else if (dz < HZ) pref = DIR_ZM;
        else              pref = DIR_LOC;
    end

    assign to_self = (pref == DIR_LOC);
endmodule

// File: rtl/defl_alloc.sv
module defl_alloc
    import router3d_pkg::*;
(
    input  logic [NREQ-1:0]          req_vld,
    input  dir_e                     req_pref [NREQ],
    input  logic [NREQ-1:0]          req_self,
    input  logic [NNET-1:0]          port_ok,
    output logic [NREQ-1:0]          req_won,
    output logic [NREQ-1:0]          out_vld,
    output logic [NREQ-1:0][PW-1:0]  out_src
);
    always_comb begin
        logic [NREQ-1:0] busy;
        logic            found;
        logic [PW-1:0]   pick;
        busy    = '0;
        req_won = '0;
        out_vld = '0;
        out_src = '0;
        for (int r = 0; r < NREQ; r++) begin
            found = 1'b0;
            pick  = '0;
            if (req_vld[r]) begin
                if (req_self[r] && !busy[LOCIDX]) begin
                    found = 1'b1;
                    pick  = PW'(LOCIDX);
                end else if (!req_self[r] && port_ok[req_pref[r]]
                             && !busy[req_pref[r]]) begin
                    found = 1'b1;
                    pick  = PW'(req_pref[r]);
                end else begin
                    for (int p = 0; p < NNET; p++) begin
                        if (!found && port_ok[p] && !busy[p]) begin
                            found = 1'b1;
                            pick  = PW'(p);
                        end
                    end
                end
            end
            if (found) begin
                busy[pick]    = 1'b1;
                out_vld[pick] = 1'b1;
                out_src[pick] = PW'(r);
                req_won[r]    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/mesh3d_defl_router.sv
module mesh3d_defl_router
    import router3d_pkg::*;
#(
    parameter int MESH_X  = 3,
    parameter int MESH_Y  = 3,
    parameter int MESH_Z  = 3,
    parameter int MY_X    = 1,
    parameter int MY_Y    = 1,
    parameter int MY_Z    = 1,
    parameter int COORD_W = 2,
    parameter int FLIT_W  = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NNET-1:0][FLIT_W-1:0]  net_in,
    output logic [NNET-1:0][FLIT_W-1:0]  net_out,
    input  logic [FLIT_W-1:0]            loc_in,
    output logic                         loc_stall,
    output logic [FLIT_W-1:0]            loc_out
);
    localparam int VB = FLIT_W - 1;
    localparam logic [NNET-1:0] EXIST = {
        (MY_Z > 0), (MY_Z < MESH_Z - 1),
        (MY_Y > 0), (MY_Y < MESH_Y - 1),
        (MY_X > 0), (MY_X < MESH_X - 1)
    };

    logic [NREQ-1:0][FLIT_W-1:0] req_flit;
    logic [NREQ-1:0]             req_vld;
    logic [NREQ-1:0]             req_self;
    dir_e                        req_pref [NREQ];
    logic [NREQ-1:0]             req_won;
    logic [NREQ-1:0]             out_vld;
    logic [NREQ-1:0][PW-1:0]     out_src;
    logic [NREQ-1:0][FLIT_W-1:0] out_nxt;
    logic [NREQ-1:0][FLIT_W-1:0] out_q;

    genvar g;
    generate
        for (g = 0; g < NREQ; g++) begin : g_req
            if (g == LOCIDX) begin : g_loc
                assign req_flit[g] = loc_in;
                assign req_vld[g]  = loc_in[VB];
            end else begin : g_net
                assign req_flit[g] = net_in[g];
                assign req_vld[g]  = net_in[g][VB] & EXIST[g];
            end
            xyz_route_unit #(
                .FLIT_W(FLIT_W), .COORD_W(COORD_W),
                .MY_X(MY_X), .MY_Y(MY_Y), .MY_Z(MY_Z)
            ) u_route (
                .flit(req_flit[g]),
                .pref(req_pref[g]),
                .to_self(req_self[g])
            );
        end
    endgenerate

    defl_alloc u_alloc (
        .req_vld(req_vld),
        .req_pref(req_pref),
        .req_self(req_self),
        .port_ok(EXIST),
        .req_won(req_won),
        .out_vld(out_vld),
        .out_src(out_src)
    );

    always_comb begin
        for (int p = 0; p < NREQ; p++)
            out_nxt[p] = out_vld[p] ? req_flit[out_src[p]] : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_nxt;
    end

    assign loc_stall = req_vld[LOCIDX] & ~req_won[LOCIDX];
    assign loc_out   = out_q[LOCIDX];
    generate
        for (g = 0; g < NNET; g++) begin : g_out
            assign net_out[g] = out_q[g];
        end
    endgenerate

    // checks
    logic [NREQ-1:0] q_vld;
    logic            live;
    always_comb begin
        for (int p = 0; p < NREQ; p++) q_vld[p] = out_q[p][VB];
    end
    always_ff @(posedge clk) begin
        if (!rst_n) live <= 1'b0;
        else        live <= 1'b1;
    end

    a_r9_conserve: assert property (@(posedge clk) disable iff (!rst_n)
        live |=> $countones(q_vld) ==
                 $past($countones(req_vld[NNET-1:0]) + 32'(req_vld[LOCIDX] & ~loc_stall)));
    a_r8_edge_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (q_vld[NNET-1:0] & ~EXIST) == '0);
    a_r3_eject_home: assert property (@(posedge clk) disable iff (!rst_n)
        loc_out[VB] |-> loc_out[VB-1 -: 3*COORD_W] ==
            {COORD_W'(MY_X), COORD_W'(MY_Y), COORD_W'(MY_Z)});
    a_r7_stall_full: assert property (@(posedge clk) disable iff (!rst_n)
        loc_stall |-> (loc_in[VB] && &(out_vld[NNET-1:0] | ~EXIST)));
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> q_vld == '0);
endmodule

// File: tb/mesh3d_defl_router_tb.sv
module mesh3d_defl_router_tb;
    localparam int CLK_P = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_P/2) clk = ~clk;

    logic [5:0][15:0] c_in, c_out, e_in, e_out;
    logic [15:0] c_lin, c_lout, e_lin, e_lout;
    logic c_stall, e_stall;

    mesh3d_defl_router u_dut (
        .clk(clk), .rst_n(rst_n), .net_in(c_in), .net_out(c_out),
        .loc_in(c_lin), .loc_stall(c_stall), .loc_out(c_lout));

    mesh3d_defl_router #(.MY_X(0), .MY_Y(0), .MY_Z(0)) u_edge (
        .clk(clk), .rst_n(rst_n), .net_in(e_in), .net_out(e_out),
        .loc_in(e_lin), .loc_stall(e_stall), .loc_out(e_lout));

    int n_chk = 0;
    int n_bad = 0;

    function automatic logic [15:0] fl(int x, int y, int z, int pay);
        return {1'b1, 2'(x), 2'(y), 2'(z), 9'(pay)};
    endfunction

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        c_in = '0; c_lin = '0; e_in = '0; e_lin = '0;
    endtask

    task automatic chk_center(string req, logic [5:0][15:0] exp, logic [15:0] exp_l);
        for (int p = 0; p < 6; p++) chk(req, c_out[p], exp[p]);
        chk(req, c_lout, exp_l);
    endtask

    task automatic t_reset();
        chk_center("R1", '0, '0);
        chk("R1", {15'd0, c_stall}, 16'd0);
    endtask

    task automatic t_xyz();
        logic [15:0] f [6];
        f[0] = fl(2,0,0,11); f[1] = fl(0,2,2,12); f[2] = fl(1,2,0,13);
        f[3] = fl(1,0,2,14); f[4] = fl(1,1,2,15); f[5] = fl(1,1,0,16);
        for (int d = 0; d < 6; d++) begin
            logic [5:0][15:0] exp;
            @(negedge clk); idle(); c_lin = f[d];
            #1 chk("R7", {15'd0, c_stall}, 16'd0);
            @(negedge clk); idle();
            exp = '0; exp[d] = f[d];
            chk_center("R2", exp, '0);
        end
        @(negedge clk); idle(); c_in[1] = fl(2,1,1,77);
        @(negedge clk); idle();
        chk("R2", c_out[0], fl(2,1,1,77));
        chk("R4", c_out[1], 16'd0);
        @(negedge clk);
        chk("R4", c_out[0], 16'd0);
    endtask

    task automatic t_eject();
        @(negedge clk); idle(); c_in[2] = fl(1,1,1,300);
        @(negedge clk); idle();
        chk_center("R3", '0, fl(1,1,1,300));
        @(negedge clk);
        chk("R4", c_lout, 16'd0);
    endtask

    task automatic t_contend();
        logic [5:0][15:0] exp;
        @(negedge clk); idle();
        c_in[1] = fl(2,1,1,1); c_in[3] = fl(2,1,1,3);
        @(negedge clk); idle();
        exp = '0; exp[0] = fl(2,1,1,1); exp[1] = fl(2,1,1,3);
        chk_center("R5", exp, '0);
    endtask

    task automatic t_double_eject();
        logic [5:0][15:0] exp;
        @(negedge clk); idle();
        c_in[2] = fl(1,1,1,2); c_in[5] = fl(1,1,1,5);
        @(negedge clk); idle();
        exp = '0; exp[0] = fl(1,1,1,5);
        chk_center("R6", exp, fl(1,1,1,2));
    endtask

    task automatic t_full();
        logic [5:0][15:0] exp;
        @(negedge clk); idle();
        for (int p = 0; p < 6; p++) c_in[p] = fl(2,1,1,20+p);
        c_lin = fl(2,1,1,99);
        #1 chk("R7", {15'd0, c_stall}, 16'd1);
        @(negedge clk); idle();
        for (int p = 0; p < 6; p++) exp[p] = fl(2,1,1,20+p);
        chk_center("R9", exp, '0);
        @(negedge clk); idle();
        for (int p = 0; p < 5; p++) c_in[p] = fl(2,1,1,40+p);
        c_lin = fl(2,1,1,98);
        #1 chk("R7", {15'd0, c_stall}, 16'd0);
        @(negedge clk); idle();
        for (int p = 0; p < 5; p++) exp[p] = fl(2,1,1,40+p);
        exp[5] = fl(2,1,1,98);
        chk_center("R7", exp, '0);
    endtask

    task automatic t_corner();
        @(negedge clk); idle();
        e_in[0] = fl(2,0,0,50); e_in[2] = fl(2,0,0,52); e_in[1] = fl(2,0,0,51);
        @(negedge clk); idle();
        chk("R5", e_out[0], fl(2,0,0,50));
        chk("R8", e_out[2], fl(2,0,0,52));
        chk("R8", e_out[1], 16'd0);
        chk("R8", e_out[3], 16'd0);
        chk("R8", e_out[5], 16'd0);
        chk("R8", e_out[4], 16'd0);
        chk("R8", e_lout, 16'd0);
    endtask

    initial begin
        idle();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_xyz();
        t_eject();
        t_contend();
        t_double_eject();
        t_full();
        t_corner();
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_P * 5000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule